// File: doc/BRIEF.md
# Base/Limit Address Guard

This block sits on the request path between a processor and its memory and keeps user-mode code inside one contiguous region. Two privileged configuration registers describe the region: a start address (base) and a size (limit). A third register picks how the incoming address is read. In window mode the address is treated as physical. It is passed through unchanged and trapped when it falls outside the half-open range starting at base and spanning limit bytes. In offset mode the address is treated as zero-based. It is trapped when it is not below limit, and otherwise base is added to it before it goes to memory. Kernel-mode requests skip every check and keep their address as it is.

The check is purely combinational from request to grant and trap. The configuration registers and a fault-address register change only on the clock edge. Each request cycle is in one of three named decisions: BYPASS for kernel requests, GRANT for legal user requests and TRAP for illegal user requests. The mode register holds one of two states, WINDOW (reset) and OFFSET. A kernel write to the mode field moves it between them: WINDOW→OFFSET when data bit 0 is 1 and OFFSET→WINDOW when it is 0. Every other cycle is a self-loop. A user-mode write to the configuration space changes nothing and raises a separate privilege trap. After reset, base and limit are both zero, so every user request traps until the kernel programs the registers.

Top module: `mpu_guard`

## Requirements
- R1: After reset, base = 0, limit = 0, mode = WINDOW and fault_addr = 0, so every user request with req_valid high traps.
- R2: When priv_kernel is 1, mem_valid equals req_valid, mem_addr equals req_addr and trap_range is 0, whatever the mode.
- R3: In WINDOW mode, a user request is granted with mem_addr = req_addr exactly when base ≤ req_addr < base + limit. Otherwise trap_range is 1.
- R4: The WINDOW upper bound base + limit is formed one bit wider than the address. A region that reaches past the top of the address space does not wrap around to admit low addresses.
- R5: In OFFSET mode, a user request is granted exactly when req_addr < limit, and mem_addr = (base + req_addr) modulo 2^AW. Otherwise trap_range is 1.
- R6: Whenever trap_range is 1, mem_valid is 0 in the same cycle.
- R7: On the clock edge that ends a trapped request, fault_addr takes the request's req_addr. It holds its value in every other cycle.
- R8: A kernel write (cfg_we = 1, priv_kernel = 1) sets the field chosen by cfg_sel from the next cycle on. The encoding is: 0 = base, 1 = limit, 2 = mode (cfg_wdata bit 0: 0 = WINDOW, 1 = OFFSET), 3 = no field.
- R9: A user write (cfg_we = 1, priv_kernel = 0) changes no field and drives trap_priv to 1 in that cycle. trap_priv is 0 in all other cycles.
- R10: A user request and a user configuration write in the same cycle are judged independently. The request is checked against the unchanged fields, and trap_priv and trap_range may both be 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 base, 1 limit, 2 mode, 3 none |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Memory request from the processor |
| req_addr | input | AW | Request address (physical or zero-based, per mode) |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_addr | output | AW | Address forwarded to memory |
| trap_range | output | 1 | Illegal user access |
| trap_priv | output | 1 | User-mode attempt to write configuration |
| fault_addr | output | AW | Address of the most recent trapped request |

## Verification
The two functions that can fire in the same cycle are the range trap and the privilege trap. Both occur when user code issues a memory request and a configuration write together. The bench provokes this with directed cycles that pair a user write with in-range and out-of-range requests, and again across a long randomized stretch. A behavioural reference model predicts each cycle's grant, trap pair and fault address from the fields as they stood before the edge. After the edge the bench confirms that the attempted write left later address decisions unchanged.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_OFFSET = 1'b1
    } guard_mode_e;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        DEC_BYPASS = 2'd0,
        DEC_GRANT  = 2'd1,
        DEC_TRAP   = 2'd2,
        DEC_IDLE   = 2'd3
    } access_dec_e;

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          priv_kernel,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output guard_mode_e   mode_q,
    output logic          priv_viol
);

    logic       wr_ok;
    cfg_field_e field;

    assign field     = cfg_field_e'(cfg_sel);
    assign wr_ok     = cfg_we && priv_kernel;
    assign priv_viol = cfg_we && !priv_kernel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            mode_q  <= MODE_WINDOW;
        end else if (wr_ok) begin
            unique case (field)
                SEL_BASE:  base_q  <= cfg_wdata;
                SEL_LIMIT: limit_q <= cfg_wdata;
                SEL_MODE:  mode_q  <= cfg_wdata[0] ? MODE_OFFSET : MODE_WINDOW;
                SEL_NONE:  ;
                default:   ;
            endcase
        end
    end

    // R9: a user-mode write leaves all fields untouched
    a_r9_user_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv_kernel) |=> ($stable(base_q) && $stable(limit_q) && $stable(mode_q)));

    // R9: the privilege trap is only ever seen from user mode
    a_r9_priv_only_user: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> !priv_kernel);

endmodule

// File: rtl/mpu_range_check.sv
module mpu_range_check
    import mpu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  guard_mode_e   mode,
    output logic          legal,
    output logic [AW-1:0] phys_addr
);

    localparam int EW = AW + 1;

    logic [EW-1:0] end_wide;
    logic          lo_ok;
    logic          hi_ok;
    logic          off_ok;
    logic [AW-1:0] reloc_sum;

    // both bounds evaluated side by side; the end is one bit wider
    assign end_wide  = {1'b0, base} + {1'b0, limit};
    assign lo_ok     = addr >= base;
    assign hi_ok     = {1'b0, addr} < end_wide;
    assign off_ok    = addr < limit;
    assign reloc_sum = base + addr;

    always_comb begin
        legal     = 1'b0;
        phys_addr = addr;
        unique case (mode)
            MODE_WINDOW: begin
                legal     = lo_ok && hi_ok;
                phys_addr = addr;
            end
            MODE_OFFSET: begin
                legal     = off_ok;
                phys_addr = reloc_sum;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mpu_fault_reg.sv
module mpu_fault_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] fault_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       fault_q <= '0;
        else if (capture) fault_q <= addr;
    end

    // R7: without a trap the fault address holds
    a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(fault_q));

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
    import mpu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          priv_kernel,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          trap_range,
    output logic          trap_priv,
    output logic [AW-1:0] fault_addr
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    guard_mode_e   mode_q;
    logic          legal;
    logic [AW-1:0] phys_addr;
    access_dec_e   dec;

    mpu_cfg_regs #(.AW(AW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_kernel (priv_kernel),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .base_q      (base_q),
        .limit_q     (limit_q),
        .mode_q      (mode_q),
        .priv_viol   (trap_priv)
    );

    mpu_range_check #(.AW(AW)) u_chk (
        .addr      (req_addr),
        .base      (base_q),
        .limit     (limit_q),
        .mode      (mode_q),
        .legal     (legal),
        .phys_addr (phys_addr)
    );

    always_comb begin
        if (!req_valid)       dec = DEC_IDLE;
        else if (priv_kernel) dec = DEC_BYPASS;
        else if (legal)       dec = DEC_GRANT;
        else                  dec = DEC_TRAP;
    end

    always_comb begin
        mem_valid  = 1'b0;
        mem_addr   = req_addr;
        trap_range = 1'b0;
        unique case (dec)
            DEC_BYPASS: begin
                mem_valid = 1'b1;
                mem_addr  = req_addr;
            end
            DEC_GRANT: begin
                mem_valid = 1'b1;
                mem_addr  = phys_addr;
            end
            DEC_TRAP: begin
                trap_range = 1'b1;
            end
            DEC_IDLE: ;
            default: ;
        endcase
    end

    mpu_fault_reg #(.AW(AW)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (trap_range),
        .addr    (req_addr),
        .fault_q (fault_addr)
    );

    // R2: kernel requests pass straight through
    a_r2_kernel_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_kernel && req_valid) |-> (mem_valid && mem_addr == req_addr && !trap_range));

    // R6: a trapped request never reaches memory
    a_r6_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        trap_range |-> !mem_valid);

    // R7: the faulting address is captured at the edge
    a_r7_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_range |=> (fault_addr == $past(req_addr)));

    // R5: a granted offset-mode user request lies below limit
    a_r5_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !priv_kernel && mode_q == MODE_OFFSET) |-> (req_addr < limit_q));

    // R3: a granted window-mode user request is not below base
    a_r3_window_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !priv_kernel && mode_q == MODE_WINDOW) |-> (req_addr >= base_q));

endmodule

// File: tb/mpu_guard_bench.sv
module mpu_guard_bench;

    localparam int AW   = 16;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv_kernel = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd3;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic          trap_range;
    logic          trap_priv;
    logic [AW-1:0] fault_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state
    int m_base = 0, m_limit = 0, m_mode = 0, m_fault = 0;

    always #2.5 clk = ~clk;

    mpu_guard #(.AW(AW)) u_mpu_guard (
        .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .mem_valid(mem_valid), .mem_addr(mem_addr),
        .trap_range(trap_range), .trap_priv(trap_priv), .fault_addr(fault_addr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit kern, input bit we, input int sel, input int wd,
                        input bit rv, input int a, input string tag);
        bit e_legal, e_valid, e_trap, e_priv;
        int e_addr;
        @(negedge clk);
        priv_kernel = kern; cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = AW'(wd);
        req_valid = rv; req_addr = AW'(a);
        #1;
        if (m_mode == 0) begin
            e_legal = (a >= m_base) && (a < m_base + m_limit);
            e_addr  = a;
        end else begin
            e_legal = a < m_limit;
            e_addr  = (m_base + a) & MASK;
        end
        if (kern) e_addr = a;
        e_trap  = rv && !kern && !e_legal;
        e_valid = rv && !e_trap;
        e_priv  = we && !kern;
        check(tag, "mem_valid", int'(mem_valid), int'(e_valid));
        check(tag, "trap_range", int'(trap_range), int'(e_trap));
        check(tag, "trap_priv", int'(trap_priv), int'(e_priv));
        check(tag, "fault_addr", int'(fault_addr), m_fault);
        if (e_valid) check(tag, "mem_addr", int'(mem_addr), e_addr);
        @(posedge clk);
        if (e_trap) m_fault = a;
        if (we && kern) begin
            case (sel)
                0: m_base  = wd & MASK;
                1: m_limit = wd & MASK;
                2: m_mode  = wd & 1;
                default: ;
            endcase
        end
    endtask

    task automatic uacc(input int a, input string tag);
        step(0, 0, 3, 0, 1, a, tag);
    endtask

    task automatic kwr(input int sel, input int wd, input string tag);
        step(1, 1, sel, wd, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, everything traps
        check("R1", "fault_addr after reset", int'(fault_addr), 0);
        uacc(16'h0000, "R1");
        uacc(16'h1234, "R1");
        // R9: user write ignored, privilege trap raised
        step(0, 1, 0, 16'h0100, 0, 0, "R9");
        step(0, 1, 1, 16'h0100, 0, 0, "R9");
        uacc(16'h0100, "R9");
        // R8: kernel programs window
        kwr(0, 16'h1000, "R8");
        kwr(1, 16'h0200, "R8");
        kwr(3, 16'hFFFF, "R8");
        // R3: window edges
        uacc(16'h0FFF, "R3");
        uacc(16'h1000, "R3");
        uacc(16'h11FF, "R3");
        uacc(16'h1200, "R3");
        // R6 and R7: trap then fault register
        uacc(16'h7777, "R6");
        step(0, 0, 3, 0, 0, 0, "R7");
        // R2: kernel bypass
        step(1, 0, 3, 0, 1, 16'h0005, "R2");
        // R10: both traps in one cycle, and in-range access with user write
        step(0, 1, 1, 16'hFFFF, 1, 16'h2000, "R10");
        step(0, 1, 0, 16'h0000, 1, 16'h1100, "R10");
        uacc(16'h1300, "R10");
        // R4: region at top of space
        kwr(0, 16'hFF00, "R4");
        kwr(1, 16'h0100, "R4");
        uacc(16'hFFFF, "R4");
        uacc(16'hFEFF, "R4");
        uacc(16'h0000, "R4");
        kwr(1, 16'h0200, "R4");
        uacc(16'h0050, "R4");
        uacc(16'hFF00, "R4");
        // R5: offset mode
        kwr(0, 16'h1000, "R5");
        kwr(2, 1, "R5");
        uacc(16'h0000, "R5");
        uacc(16'h01FF, "R5");
        uacc(16'h0200, "R5");
        step(1, 0, 3, 0, 1, 16'h0200, "R5");
        kwr(0, 16'hFFF0, "R5");
        uacc(16'h0020, "R5");
        kwr(2, 0, "R8");
        uacc(16'hFFF0, "R8");
        // randomized stretch
        for (int i = 0; i < 2000; i++) begin
            bit k, w, v;
            int s, d, a;
            k = ($urandom % 4) == 0;
            w = ($urandom % 6) == 0;
            s = $urandom % 4;
            d = ($urandom % 3 == 0) ? ($urandom & MASK) : ($urandom % 64);
            if (s == 0 && $urandom % 2 == 0) d = ($urandom % 2) ? 16'hFFC0 : 16'h0040;
            v = ($urandom % 5) != 0;
            if ($urandom % 4 == 0) a = $urandom & MASK;
            else if (m_mode == 0) a = (m_base + ($urandom % (m_limit + 8)) - 4) & MASK;
            else a = ($urandom % (m_limit + 8)) & MASK;
            step(k, w, s, d, v, a, "R10");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule